// File: doc/BRIEF.md
# Descriptor-Driven Waveform Sequencer

This block is a bus master whose waveform is set by a stored table and not by fixed logic. Four waveform descriptors sit in an internal table of seven working entries each. A write port fills the table while the engine is idle. A start pulse selects one descriptor and loads a start address. The engine then walks the descriptor's entries one clock at a time. Each entry either holds the levels of six control lines for a set number of clocks, or tests one synchronized ready input to pick the next entry. A 3-bit state output shows the active entry number, and the value 7 means idle.

Action entries can also move one data word. In a drive action the word comes from the FIFO side and goes out on the bus. In a sample action the word comes from the bus and goes into the FIFO side. An action entry can also bump the 9-bit address by one. Control levels change on any clock, so read and write strobes of any width and polarity are set entirely by the table. The engine's clock is forwarded unchanged to an output pin for the attached peripheral.

Top module: `wfe_engine`

## Requirements
- R1: After reset, state_o is 7, ctl_o equals the idle level (all zero by default), and addr_o, done, busy, bus_oe, fifo_rd and fifo_wr are all 0.
- R2: When go is high while idle, the edge moves state_o to 0, loads addr_o from go_addr and latches go_desc. go is ignored while busy: state, address and control outputs carry on unchanged.
- R3: An action entry keeps ctl_o at its control field [5:0] for max(dwell,1) clocks, where dwell is field [16:9]. It then moves to the state in field [19:17], and 7 ends the transaction. Bit 23 is 0 for action entries.
- R4: addr_o changes during a transaction only on the last clock of an action entry with bit 6 set. It then steps by one, modulo 512, so 511 wraps to 0.
- R5: A decision entry (bit 23 set) lasts one clock. It goes to field [5:3] if the synchronized ready input indexed by field [2:0] is 1, and otherwise to field [8:6]. Indices 6 and 7 read as 0. During the decision, ctl_o holds the last action level of the same transaction, or the idle level if there was none.
- R6: Ready inputs pass through two flip-flops before they are tested, so a decision that is one clock after a ready change still sees the old value.
- R7: In an action entry whose data field [8:7] is 01 (drive), bus_oe is high for the whole entry and bus_dout equals fifo_din. fifo_rd pulses only on the entry's last clock.
- R8: In an action entry whose data field is 10 (sample), fifo_wr pulses on the entry's last clock and fifo_dout equals bus_din. Codes 00 and 11 move no data.
- R9: done is high for exactly the one clock in which state_o first returns to 7, and busy is high whenever state_o is not 7.
- R10: Each transaction runs the entries of the descriptor selected at its start. Table writes made while busy are discarded.
- R11: clk_out follows clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_out | output | 1 | Forwarded clock for the peripheral |
| cfg_we | input | 1 | Table write strobe |
| cfg_desc | input | 2 | Descriptor number to write |
| cfg_state | input | 3 | Entry number to write (0-6) |
| cfg_data | input | 24 | Entry contents |
| go | input | 1 | Start request |
| go_desc | input | 2 | Descriptor to run |
| go_addr | input | 9 | Start address |
| rdy_in | input | 6 | Asynchronous ready inputs |
| ctl_o | output | 6 | Control line levels |
| addr_o | output | 9 | Bus address |
| state_o | output | 3 | Active entry, 7 = idle |
| done | output | 1 | One-clock end-of-transaction pulse |
| busy | output | 1 | Transaction in progress |
| bus_din | input | 16 | Data from the bus |
| bus_dout | output | 16 | Data to the bus |
| bus_oe | output | 1 | Bus output enable |
| fifo_din | input | 16 | Word supplied by the FIFO side |
| fifo_rd | output | 1 | FIFO-side word consumed |
| fifo_dout | output | 16 | Word delivered to the FIFO side |
| fifo_wr | output | 1 | FIFO-side word delivered |

## Verification
The assertions check on every clock the properties that follow from the ports alone. done appears only in idle and lasts one clock. Idle holds without a start. A start lands in state 0 with the requested address. The address moves by at most one step while busy. The FIFO strobes never overlap, and a read strobe always comes with the bus enabled. Only the bench's scenarios can show the rest, because it must be compared against the programmed table. That covers dwell lengths, branch targets, held control levels during decisions, the two-clock ready latency, discarded busy-time writes, and the choice of descriptor.

// File: rtl/wfe_pkg.sv
// Shared constants, entry layouts and data-action codes for the waveform engine.
// Assumes the 24-bit entry layout stated in the brief; field positions are behaviour.
package wfe_pkg;
    localparam int ADDR_W  = 9;
    localparam int CTL_W   = 6;
    localparam int RDY_W   = 6;
    localparam int ST_W    = 3;
    localparam int DESC_N  = 4;
    localparam int DESC_W  = $clog2(DESC_N);
    localparam int WORK_N  = (1 << ST_W) - 1;
    localparam int DWELL_W = 8;
    localparam int IDX_W   = 3;
    localparam int ENTRY_W = 24;
    localparam logic [ST_W-1:0] ST_IDLE = ST_W'(WORK_N);

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_DRIVE  = 2'b01,
        OP_SAMPLE = 2'b10,
        OP_SPARE  = 2'b11
    } data_op_e;

    typedef struct packed {
        logic               is_dec;
        logic [2:0]         spare;
        logic [ST_W-1:0]    next;
        logic [DWELL_W-1:0] dwell;
        data_op_e           op;
        logic               inc;
        logic [CTL_W-1:0]   ctl;
    } act_t;

    typedef struct packed {
        logic               is_dec;
        logic [13:0]        spare;
        logic [ST_W-1:0]    tgt_f;
        logic [ST_W-1:0]    tgt_t;
        logic [IDX_W-1:0]   idx;
    } dec_t;

    // Cleared entry: one-clock action that ends the transaction.
    localparam logic [ENTRY_W-1:0] ENTRY_RST =
        {1'b0, 3'b000, ST_IDLE, {DWELL_W{1'b0}}, 2'b00, 1'b0, {CTL_W{1'b0}}};
endpackage

// File: rtl/wfe_desc_table.sv
// Descriptor table: DESC_N descriptors of WORK_N entries each.
// Writes are dropped while locked; reads are combinational; entry 7 reads as idle.
module wfe_desc_table
    import wfe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock,
    input  logic               wr_en,
    input  logic [DESC_W-1:0]  wr_desc,
    input  logic [ST_W-1:0]    wr_state,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [DESC_W-1:0]  rd_desc,
    input  logic [ST_W-1:0]    rd_state,
    output logic [ENTRY_W-1:0] rd_entry
);
    logic [ENTRY_W-1:0] mem [DESC_N][WORK_N];

    // Store or clear table entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < DESC_N; d++)
                for (int s = 0; s < WORK_N; s++)
                    mem[d][s] <= ENTRY_RST;
        end else if (wr_en && !lock && wr_state != ST_IDLE) begin
            mem[wr_desc][wr_state] <= wr_data;
        end
    end

    // Read the entry for the active descriptor and state.
    always_comb begin
        if (rd_state == ST_IDLE) rd_entry = ENTRY_RST;
        else                     rd_entry = mem[rd_desc][rd_state];
    end
endmodule

// File: rtl/wfe_rdy_sync.sv
// Two-flop synchronizer, one chain per ready input.
// Assumes ready inputs are level signals slower than the engine clock.
module wfe_rdy_sync #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_chain
        logic meta, sync;
        // Two-stage capture of one ready bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= 1'b0;
                sync <= 1'b0;
            end else begin
                meta <= din[i];
                sync <= meta;
            end
        end
        assign dout[i] = sync;
    end
endmodule

// File: rtl/wfe_seq.sv
// Sequencer: walks descriptor entries, times dwell, steps address, branches on ready.
// Assumes the entry presented matches the current state and selected descriptor.
module wfe_seq
    import wfe_pkg::*;
#(
    parameter logic [CTL_W-1:0] CTL_IDLE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [DESC_W-1:0]  go_desc,
    input  logic [ADDR_W-1:0]  go_addr,
    input  logic [ENTRY_W-1:0] entry,
    input  logic [RDY_W-1:0]   rdy_s,
    output logic [ST_W-1:0]    st,
    output logic [DESC_W-1:0]  desc_q,
    output logic [ADDR_W-1:0]  addr_q,
    output logic [CTL_W-1:0]   ctl,
    output logic               done,
    output logic               busy,
    output logic               bus_oe,
    output logic               fifo_rd,
    output logic               fifo_wr
);
    localparam int IDX_N = 1 << IDX_W;

    act_t               act;
    dec_t               dec;
    logic               idle, is_dec, last, hit, leave;
    logic [DWELL_W-1:0] dwell_eff, cnt;
    logic [ST_W-1:0]    nxt;
    logic [CTL_W-1:0]   hold;
    logic [IDX_N-1:0]   rdy_pad;

    assign act     = act_t'(entry);
    assign dec     = dec_t'(entry);
    assign idle    = (st == ST_IDLE);
    assign is_dec  = dec.is_dec;
    assign rdy_pad = {{(IDX_N-RDY_W){1'b0}}, rdy_s};
    assign hit     = rdy_pad[dec.idx];

    // Effective dwell and last-clock detection for action entries.
    always_comb begin
        dwell_eff = (act.dwell == '0) ? DWELL_W'(1) : act.dwell;
        last      = (cnt == dwell_eff - DWELL_W'(1));
        leave     = is_dec || last;
    end

    // Next-state choice.
    always_comb begin
        if (idle)        nxt = go ? '0 : ST_IDLE;
        else if (is_dec) nxt = hit ? dec.tgt_t : dec.tgt_f;
        else if (last)   nxt = act.next;
        else             nxt = st;
    end

    // State, dwell counter, address, descriptor latch, held control and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            desc_q <= '0;
            hold   <= CTL_IDLE;
            done   <= 1'b0;
        end else begin
            st   <= nxt;
            done <= !idle && (nxt == ST_IDLE);
            cnt  <= (idle || leave) ? '0 : cnt + DWELL_W'(1);
            if (idle && go) begin
                addr_q <= go_addr;
                desc_q <= go_desc;
                hold   <= CTL_IDLE;
            end else if (!idle && !is_dec) begin
                hold <= act.ctl;
                if (act.inc && last) addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    // Output decode from the active entry.
    always_comb begin
        busy    = !idle;
        ctl     = idle ? CTL_IDLE : (is_dec ? hold : act.ctl);
        bus_oe  = !idle && !is_dec && (act.op == OP_DRIVE);
        fifo_rd = bus_oe && last;
        fifo_wr = !idle && !is_dec && (act.op == OP_SAMPLE) && last;
    end
endmodule

// File: rtl/wfe_engine.sv
// Top of the descriptor-driven waveform engine: table, ready synchronizer, sequencer.
// Assumes a single synchronous clock domain; the clock is forwarded to clk_out.
module wfe_engine
    import wfe_pkg::*;
#(
    parameter int               DATA_W   = 16,
    parameter logic [CTL_W-1:0] CTL_IDLE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               clk_out,
    input  logic               cfg_we,
    input  logic [DESC_W-1:0]  cfg_desc,
    input  logic [ST_W-1:0]    cfg_state,
    input  logic [ENTRY_W-1:0] cfg_data,
    input  logic               go,
    input  logic [DESC_W-1:0]  go_desc,
    input  logic [ADDR_W-1:0]  go_addr,
    input  logic [RDY_W-1:0]   rdy_in,
    output logic [CTL_W-1:0]   ctl_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [ST_W-1:0]    state_o,
    output logic               done,
    output logic               busy,
    input  logic [DATA_W-1:0]  bus_din,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               bus_oe,
    input  logic [DATA_W-1:0]  fifo_din,
    output logic               fifo_rd,
    output logic [DATA_W-1:0]  fifo_dout,
    output logic               fifo_wr
);
    logic [ENTRY_W-1:0] entry;
    logic [RDY_W-1:0]   rdy_s;
    logic [DESC_W-1:0]  desc_q;

    assign clk_out   = clk;
    assign bus_dout  = fifo_din;
    assign fifo_dout = bus_din;

    wfe_desc_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (busy),
        .wr_en    (cfg_we),
        .wr_desc  (cfg_desc),
        .wr_state (cfg_state),
        .wr_data  (cfg_data),
        .rd_desc  (desc_q),
        .rd_state (state_o),
        .rd_entry (entry)
    );

    wfe_rdy_sync #(.WIDTH(RDY_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rdy_in),
        .dout  (rdy_s)
    );

    wfe_seq #(.CTL_IDLE(CTL_IDLE)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .go_desc (go_desc),
        .go_addr (go_addr),
        .entry   (entry),
        .rdy_s   (rdy_s),
        .st      (state_o),
        .desc_q  (desc_q),
        .addr_q  (addr_o),
        .ctl     (ctl_o),
        .done    (done),
        .busy    (busy),
        .bus_oe  (bus_oe),
        .fifo_rd (fifo_rd),
        .fifo_wr (fifo_wr)
    );
endmodule

// File: rtl/wfe_engine_chk.sv
// Port-level property checker for wfe_engine, attached with bind.
// Assumes state 7 is idle and the address is 9 bits.
module wfe_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic [8:0] go_addr,
    input logic [2:0] state_o,
    input logic [8:0] addr_o,
    input logic       done,
    input logic       busy,
    input logic       bus_oe,
    input logic       fifo_rd,
    input logic       fifo_wr
);
    // R9
    done_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_o == 3'd7));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (state_o != 3'd7));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd7 && !go) |=> (state_o == 3'd7));
    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd7 && go) |=> (state_o == 3'd0 && addr_o == $past(go_addr)));
    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 3'd7) |=> (addr_o == $past(addr_o) || addr_o == $past(addr_o) + 9'd1));
    // R7
    rd_with_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> bus_oe);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_rd, fifo_wr}));
endmodule

bind wfe_engine wfe_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .go_addr (go_addr),
    .state_o (state_o),
    .addr_o  (addr_o),
    .done    (done),
    .busy    (busy),
    .bus_oe  (bus_oe),
    .fifo_rd (fifo_rd),
    .fifo_wr (fifo_wr)
);

// File: tb/sim_wfe_engine.sv
// Bench for wfe_engine: directed corners plus seeded random descriptors,
// checked cycle by cycle against a bench-side model of the requirements.
module sim_wfe_engine;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        clk_out;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_desc = '0;
    logic [2:0]  cfg_state = '0;
    logic [23:0] cfg_data = '0;
    logic        go = 1'b0;
    logic [1:0]  go_desc = '0;
    logic [8:0]  go_addr = '0;
    logic [5:0]  rdy_in = '0;
    logic [5:0]  ctl_o;
    logic [8:0]  addr_o;
    logic [2:0]  state_o;
    logic        done, busy, bus_oe, fifo_rd, fifo_wr;
    logic [15:0] bus_din = '0, bus_dout, fifo_din = '0, fifo_dout;

    int n_chk = 0, n_fail = 0;
    logic [23:0] bd [4][7];

    always #(CLK_P/2) clk = ~clk;

    wfe_engine u0 (
        .clk(clk), .rst_n(rst_n), .clk_out(clk_out),
        .cfg_we(cfg_we), .cfg_desc(cfg_desc), .cfg_state(cfg_state), .cfg_data(cfg_data),
        .go(go), .go_desc(go_desc), .go_addr(go_addr), .rdy_in(rdy_in),
        .ctl_o(ctl_o), .addr_o(addr_o), .state_o(state_o), .done(done), .busy(busy),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .fifo_din(fifo_din), .fifo_rd(fifo_rd), .fifo_dout(fifo_dout), .fifo_wr(fifo_wr)
    );

    function automatic logic [23:0] mk_act(input logic [5:0] c, input logic inc,
            input logic [1:0] op, input logic [7:0] dw, input logic [2:0] nx);
        return {1'b0, 3'b000, nx, dw, op, inc, c};
    endfunction

    function automatic logic [23:0] mk_dec(input logic [2:0] idx, input logic [2:0] t,
            input logic [2:0] f);
        return {1'b1, 14'd0, f, t, idx};
    endfunction

    function automatic logic [7:0] eff_dwell(input logic [23:0] e);
        return (e[16:9] == 8'd0) ? 8'd1 : e[16:9];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic put(input int d, input int s, input logic [23:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_desc = 2'(d); cfg_state = 3'(s); cfg_data = v;
        bd[d][s] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Start a transaction and follow it with the model until idle.
    task automatic run_txn(input int d, input logic [8:0] a);
        logic [2:0] ms;
        logic [7:0] mc;
        logic [8:0] ma;
        logic [5:0] mh;
        logic [23:0] e;
        logic lst, hit;
        int guard;
        @(negedge clk);
        go = 1'b1; go_desc = 2'(d); go_addr = a;
        @(negedge clk);
        go = 1'b0;
        ms = 3'd0; mc = 8'd0; ma = a; mh = 6'd0; guard = 0;
        while (ms != 3'd7 && guard < 4000) begin
            guard++;
            fifo_din = 16'($urandom); bus_din = 16'($urandom);
            #1;
            e = bd[d][ms];
            chk("R3 state", {29'd0, state_o}, {29'd0, ms});
            chk("R4 addr", {23'd0, addr_o}, {23'd0, ma});
            chk("R9 busy/done", {30'd0, busy, done}, 32'd2);
            if (e[23]) begin
                chk("R5 held ctl", {26'd0, ctl_o}, {26'd0, mh});
                chk("R5 no data", {29'd0, bus_oe, fifo_rd, fifo_wr}, 32'd0);
                hit = (e[2:0] < 3'd6) ? rdy_in[e[2:0]] : 1'b0;
                ms = hit ? e[5:3] : e[8:6];
                mc = 8'd0;
            end else begin
                lst = (mc == eff_dwell(e) - 8'd1);
                chk("R3 ctl", {26'd0, ctl_o}, {26'd0, e[5:0]});
                chk("R7 oe", {31'd0, bus_oe}, {31'd0, e[8:7] == 2'b01});
                chk("R7 rd", {31'd0, fifo_rd}, {31'd0, (e[8:7] == 2'b01) && lst});
                chk("R8 wr", {31'd0, fifo_wr}, {31'd0, (e[8:7] == 2'b10) && lst});
                if (e[8:7] == 2'b01) chk("R7 data", {16'd0, bus_dout}, {16'd0, fifo_din});
                if (e[8:7] == 2'b10) chk("R8 data", {16'd0, fifo_dout}, {16'd0, bus_din});
                mh = e[5:0];
                if (lst) begin
                    if (e[6]) ma = ma + 9'd1;
                    ms = e[19:17];
                    mc = 8'd0;
                end else begin
                    mc = mc + 8'd1;
                end
            end
            @(negedge clk);
        end
        chk("R9 idle", {29'd0, state_o}, 32'd7);
        chk("R9 done high", {31'd0, done}, 32'd1);
        chk("R1 idle ctl", {26'd0, ctl_o}, 32'd0);
        @(negedge clk);
        chk("R9 done pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int d = 0; d < 4; d++)
            for (int s = 0; s < 7; s++) bd[d][s] = {1'b0, 3'b000, 3'd7, 17'd0};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 state", {29'd0, state_o}, 32'd7);
        chk("R1 outs", {ctl_o, addr_o, done, busy, bus_oe, fifo_rd, fifo_wr},
            32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 forwarded clock
        chk("R11 low", {31'd0, clk_out}, 32'd0);
        @(posedge clk); #(CLK_P/4);
        chk("R11 high", {31'd0, clk_out}, 32'd1);

        // Directed descriptor 0: drive, decision, sample / short exit.
        put(0, 0, mk_act(6'h15, 1'b1, 2'b01, 8'd3, 3'd1));
        put(0, 1, mk_dec(3'd2, 3'd2, 3'd3));
        put(0, 2, mk_act(6'h2A, 1'b0, 2'b10, 8'd1, 3'd7));
        put(0, 3, mk_act(6'h3F, 1'b1, 2'b11, 8'd0, 3'd7));
        rdy_in = 6'b000000; repeat (3) @(negedge clk);
        run_txn(0, 9'h010);                  // R5 false branch
        rdy_in = 6'b000100; repeat (3) @(negedge clk);
        run_txn(0, 9'h020);                  // R5 true branch
        // R4 wrap at the top of the address range
        run_txn(0, 9'h1FF);
        @(negedge clk);
        chk("R4 wrap", {23'd0, addr_o}, 32'd0);

        // R6 latency: ready rises with the start, decision sees the old value.
        put(1, 0, mk_dec(3'd0, 3'd1, 3'd2));
        put(1, 1, mk_act(6'h01, 1'b0, 2'b00, 8'd1, 3'd7));
        put(1, 2, mk_act(6'h02, 1'b0, 2'b00, 8'd1, 3'd7));
        rdy_in = 6'b000000; repeat (3) @(negedge clk);
        go = 1'b1; go_desc = 2'd1; go_addr = 9'd0; rdy_in = 6'b000001;
        @(negedge clk); go = 1'b0;
        @(negedge clk);
        chk("R6 old ready", {29'd0, state_o}, 32'd2);
        repeat (3) @(negedge clk);
        run_txn(1, 9'd5);                    // settled ready takes the true branch

        // R2 / R10 / R3 long dwell: start and table write while busy are ignored.
        put(2, 0, mk_act(6'h0C, 1'b1, 2'b00, 8'd255, 3'd7));
        @(negedge clk);
        go = 1'b1; go_desc = 2'd2; go_addr = 9'h040;
        @(negedge clk); go = 1'b0;
        repeat (5) @(negedge clk);
        go = 1'b1; go_desc = 2'd3; go_addr = 9'h055;
        cfg_we = 1'b1; cfg_desc = 2'd2; cfg_state = 3'd0; cfg_data = mk_act(6'h33, 1'b0, 2'b00, 8'd1, 3'd7);
        @(negedge clk); go = 1'b0; cfg_we = 1'b0;
        chk("R2 ignore go state", {29'd0, state_o}, 32'd0);
        chk("R2 ignore go addr", {23'd0, addr_o}, 32'h040);
        chk("R10 busy write ctl", {26'd0, ctl_o}, 32'h0C);
        while (busy) @(negedge clk);
        chk("R4 inc after dwell", {23'd0, addr_o}, 32'h041);
        run_txn(2, 9'h100);                  // R10 stored entry unchanged, R3 255 clocks

        // Random descriptors, forward-only, checked by the model.
        for (int it = 0; it < 40; it++) begin
            int d;
            d = 1 + int'($urandom % 3);
            for (int s = 0; s < 7; s++) begin
                logic [2:0] t1, t2;
                t1 = 3'(s + 1 + int'($urandom % (7 - s)));
                t2 = 3'(s + 1 + int'($urandom % (7 - s)));
                if (s < 6 && ($urandom % 4) == 0)
                    put(d, s, mk_dec(3'($urandom), t1, t2));
                else
                    put(d, s, mk_act(6'($urandom), 1'($urandom), 2'($urandom),
                        8'($urandom % 5), t1));
            end
            rdy_in = 6'($urandom);
            repeat (3) @(negedge clk);
            run_txn(d, 9'($urandom));        // R3 R4 R5 R7 R8 R9 R10
        end
        finish_run();
    end
endmodule